// File: doc/BRIEF.md
# Parallel Flash Bus Interface Front End

This block is the device-side front end of an asynchronous parallel flash memory, rebuilt in a single synchronous clock domain. It samples the three active-low strobes (chip select, write strobe, output strobe), the word address and the incoming data bus. From them it classifies the bus into one of five states: standby, output disabled, read, write, and the illegal case where write and output strobes are both low. During a read it turns on the data output driver and presents the word that the storage array returns for the sampled address. A write is handed to the command logic behind it as a single-cycle pulse carrying an address and a data word.

A write is framed by the overlap of chip select and write strobe. The address is taken when the second of the two goes low. The data is taken when the first of the two goes high. The output strobe must stay high for the whole overlap, or no write is issued. Short pulses on chip select or write strobe are filtered out. An inactivity timer raises an automatic-standby flag once the bus has been quiet for long enough. Every time in the block is given in picoseconds through parameters, together with the clock period the block assumes, and is turned into cycle counts when the block is built.

Top module: `flash_bus_frontend`

## Requirements
- R1: While reset is low and on the first cycle after it, `dq_oe` is 0, `write_valid` is 0, `idle_standby` is 0, `standby` is 1 and `bus_op` is 0 (standby).
- R2: With chip select and output strobe low and write strobe high, `bus_op` is 2 (read), `dq_oe` is 1, and `dq_out` equals `array_rdata` for the address presented on `array_addr`, which follows `addr`.
- R3: With chip select low and output strobe high, `dq_oe` is 0. `bus_op` is 1 (output disabled) when write strobe is high and 3 (write) when it is low.
- R4: With chip select high, `bus_op` is 0, `standby` is 1 and `dq_oe` is 0, whatever the other two strobes are doing.
- R5: A write's `wr_addr` is the address present when the later of chip select and write strobe went low. Address changes during the overlap do not alter it.
- R6: A write's `wr_data` is the data present when the earlier of chip select and write strobe went high. Each completed write raises `write_valid` for exactly one cycle.
- R7: If the output strobe is low while chip select and write strobe are both low, no write is issued. That case reports `bus_op` 4 and `dq_oe` 0, and it also cancels a write already in progress.
- R8: A low pulse on chip select or write strobe shorter than GLITCH_CYCLES = ceil(GLITCH_PS/TICK_PS) cycles (5 by default) causes no bus operation. A pulse of exactly that length is acted on.
- R9: `idle_standby` rises on the clock edge 2 + IDLE_CYCLES edges after the first edge that sampled the last change of address or strobe, with IDLE_CYCLES = ceil(IDLE_PS/TICK_PS) (150 by default). It is still low one edge earlier.
- R10: Any change of address or strobe clears `idle_standby` within three edges. While the flag is set, a read in progress keeps `dq_oe` at 1 with valid data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| addr | input | ADDR_W | Word address from the bus |
| dq_in | input | DATA_W | Data arriving from the bus |
| dq_out | output | DATA_W | Data toward the bus during reads, zero otherwise |
| dq_oe | output | 1 | Output driver enable for the data bus |
| array_addr | output | ADDR_W | Synchronised address sent to the storage array |
| array_rdata | input | DATA_W | Word returned by the storage array |
| bus_op | output | 3 | Bus state: 0 standby, 1 output disabled, 2 read, 3 write, 4 contention |
| standby | output | 1 | Chip select is inactive |
| idle_standby | output | 1 | Bus quiet for the idle time |
| write_valid | output | 1 | One-cycle pulse when a write completes |
| wr_addr | output | ADDR_W | Address of the latest write |
| wr_data | output | DATA_W | Data of the latest write |

## Verification
The hardest situations to reach are the ones where timing alone decides the outcome: a strobe pulse one cycle shorter than the filter length next to one of exactly that length, and the single edge on which the idle flag switches. The stimulus changes inputs only on falling clock edges and counts pulse widths and quiet time in whole cycles. Because of that, the four-cycle and five-cycle glitches and the 151st and 152nd edges after a change are reached exactly. Write framing is tested by holding one strobe low, moving the other, and changing address and data inside the overlap. This shows which edge captured each value.

// File: rtl/flash_bus_pkg.sv
// Shared types for the flash bus front end.
package flash_bus_pkg;

    // Bus state encoding, also driven on the bus_op port.
    typedef enum logic [2:0] {
        OP_STANDBY     = 3'd0,
        OP_OUT_DISABLE = 3'd1,
        OP_READ        = 3'd2,
        OP_WRITE       = 3'd3,
        OP_CONTENTION  = 3'd4
    } fbi_op_e;

    // Rounds a time up to a whole number of clock ticks.
    function automatic int ticks_ceil(input int time_ps, input int tick_ps);
        return (time_ps + tick_ps - 1) / tick_ps;
    endfunction

endpackage

// File: rtl/fbi_strobe_filter.sv
// Two-flop synchroniser followed by an optional glitch filter.
// The clean output changes only after the synchronised input has differed
// from it for FILT_CYCLES consecutive cycles. FILT_CYCLES = 0 bypasses the filter.
// Assumes an idle-high (active-low) strobe, so both stages reset to 1.
module fbi_strobe_filter #(
    parameter int FILT_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic sync_n,
    output logic clean_n
);
    logic meta_n;

    // Two-stage metastability guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_n <= 1'b1;
            sync_n <= 1'b1;
        end else begin
            meta_n <= strobe_n;
            sync_n <= meta_n;
        end
    end

    generate
        if (FILT_CYCLES == 0) begin : g_bypass
            assign clean_n = sync_n;
        end else begin : g_filter
            localparam int CNT_W = $clog2(FILT_CYCLES + 1);
            logic [CNT_W-1:0] run_cnt;
            logic             held_n;

            // Accepts a new level only after it has persisted long enough.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_cnt <= '0;
                    held_n  <= 1'b1;
                end else if (sync_n == held_n) begin
                    run_cnt <= '0;
                end else if (run_cnt == CNT_W'(FILT_CYCLES - 1)) begin
                    run_cnt <= '0;
                    held_n  <= sync_n;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
            assign clean_n = held_n;
        end
    endgenerate
endmodule

// File: rtl/fbi_op_decode.sv
// Classifies the filtered strobes into a bus state and frames writes.
// A write arms when chip select and write strobe become low together with
// the output strobe high, and completes when either rises. Assumes address
// and data are already synchronised and held across the strobe edges.
module fbi_op_decode
    import flash_bus_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output fbi_op_e           op,
    output logic              drive,
    output logic              write_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic overlap, overlap_q, armed;

    assign overlap = !ce_n && !we_n;

    // Bus state from the strobe levels.
    always_comb begin
        if (ce_n)              op = OP_STANDBY;
        else if (we_n && !oe_n) op = OP_READ;
        else if (!we_n && oe_n) op = OP_WRITE;
        else if (!we_n)        op = OP_CONTENTION;
        else                   op = OP_OUT_DISABLE;
    end

    // The driver is enabled only by a genuine read.
    assign drive = !ce_n && !oe_n && we_n;

    // Write framing: address at overlap start, data at overlap end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlap_q   <= 1'b0;
            armed       <= 1'b0;
            write_valid <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            overlap_q   <= overlap;
            write_valid <= 1'b0;
            if (overlap && !overlap_q && oe_n) begin
                armed   <= 1'b1;
                wr_addr <= addr_s;
            end else if (armed && !oe_n) begin
                armed <= 1'b0;
            end else if (armed && !overlap) begin
                armed       <= 1'b0;
                wr_data     <= data_s;
                write_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbi_idle_timer.sv
// Raises a flag once the watched bus state has stayed unchanged for
// IDLE_CYCLES cycles. Any change clears the count and the flag.
// Assumes the watched vector is already synchronous to clk.
module fbi_idle_timer #(
    parameter int WATCH_W     = 22,
    parameter int IDLE_CYCLES = 150
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WATCH_W-1:0] watch,
    output logic               idle_flag
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

    logic [WATCH_W-1:0] watch_q;
    logic [CNT_W-1:0]   quiet_cnt;
    logic               activity;

    assign activity = (watch != watch_q);

    // Keeps the previous state so that changes can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) watch_q <= '0;
        else        watch_q <= watch;
    end

    // Counts quiet cycles and sets the flag at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || activity) begin
            quiet_cnt <= '0;
            idle_flag <= 1'b0;
        end else if (!idle_flag) begin
            quiet_cnt <= quiet_cnt + 1'b1;
            if (quiet_cnt == CNT_W'(IDLE_CYCLES - 1)) idle_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_bus_frontend.sv
// Device-side front end of an asynchronous parallel flash bus.
// Synchronises the strobes, address and data, filters short pulses on chip
// select and write strobe, decodes the bus state, frames writes and keeps
// an inactivity timer. All times are in ps and assume a clock of TICK_PS.
module flash_bus_frontend
    import flash_bus_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 16,
    parameter int TICK_PS   = 1000,
    parameter int GLITCH_PS = 5000,
    parameter int IDLE_PS   = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] array_addr,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [2:0]        bus_op,
    output logic              standby,
    output logic              idle_standby,
    output logic              write_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int GLITCH_CYCLES = ticks_ceil(GLITCH_PS, TICK_PS);
    localparam int IDLE_CYCLES   = ticks_ceil(IDLE_PS, TICK_PS);
    localparam int NSTROBE       = 3;   // index 0 chip select, 1 write, 2 output

    logic [NSTROBE-1:0] strobe_raw, strobe_sync, strobe_clean;
    logic [ADDR_W-1:0]  addr_m, addr_s;
    logic [DATA_W-1:0]  data_m, data_s;
    logic               drive;
    fbi_op_e            op;

    assign strobe_raw = {oe_n, we_n, ce_n};

    // Chip select and write strobe are filtered; the output strobe is only synchronised.
    for (genvar i = 0; i < NSTROBE; i++) begin : g_strobe
        fbi_strobe_filter #(
            .FILT_CYCLES((i < 2) ? GLITCH_CYCLES : 0)
        ) i_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe_n(strobe_raw[i]),
            .sync_n  (strobe_sync[i]),
            .clean_n (strobe_clean[i])
        );
    end

    // Two-flop synchronisers for the address and data buses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_m <= '0;
            addr_s <= '0;
            data_m <= '0;
            data_s <= '0;
        end else begin
            addr_m <= addr;
            addr_s <= addr_m;
            data_m <= dq_in;
            data_s <= data_m;
        end
    end

    fbi_op_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (strobe_clean[0]),
        .we_n       (strobe_clean[1]),
        .oe_n       (strobe_clean[2]),
        .addr_s     (addr_s),
        .data_s     (data_s),
        .op         (op),
        .drive      (drive),
        .write_valid(write_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    fbi_idle_timer #(
        .WATCH_W    (ADDR_W + NSTROBE),
        .IDLE_CYCLES(IDLE_CYCLES)
    ) i_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .watch    ({strobe_sync, addr_s}),
        .idle_flag(idle_standby)
    );

    assign bus_op     = op;
    assign standby    = strobe_clean[0];
    assign dq_oe      = drive;
    assign dq_out     = drive ? array_rdata : '0;
    assign array_addr = addr_s;
endmodule

// File: rtl/flash_bus_frontend_chk.sv
// Property checker for flash_bus_frontend, attached by bind.
module flash_bus_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_op,
    input logic       standby,
    input logic       dq_oe,
    input logic       idle_standby,
    input logic       write_valid
);
    // R6
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_valid |=> !write_valid);

    // R4
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!dq_oe && bus_op == 3'd0));

    // R3
    disable_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 3'd1 || bus_op == 3'd3) |-> !dq_oe);

    // R7
    wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_valid |-> $past(bus_op, 2) == 3'd3);

    // R7
    contention_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 3'd4) |-> (!dq_oe && !write_valid));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_standby) |-> $stable(bus_op));
endmodule

bind flash_bus_frontend flash_bus_frontend_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_op      (bus_op),
    .standby     (standby),
    .dq_oe       (dq_oe),
    .idle_standby(idle_standby),
    .write_valid (write_valid)
);

// File: tb/test_flash_bus_frontend.sv
`timescale 1ns/1ps
// Self-checking bench. The design keeps its default 1 ns tick, so all timing
// is counted in clock cycles. Inputs change on falling edges only.
module test_flash_bus_frontend;
    localparam int AW       = 19;
    localparam int DW       = 16;
    localparam int GLITCH_C = 5;    // ceil(5000/1000)
    localparam int IDLE_C   = 150;  // ceil(150000/1000)
    localparam int SETTLE   = 12;

    // Fields: [7] ce_n, [6] we_n, [5] oe_n, [4:2] bus_op, [1] dq_oe, [0] standby
    localparam logic [7:0] VEC [0:7] = '{
        8'b111_000_0_1, 8'b100_000_0_1, 8'b110_000_0_1, 8'b011_001_0_0,
        8'b010_010_1_0, 8'b001_011_0_0, 8'b000_100_0_0, 8'b101_000_0_1
    };

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, we_n = 1, oe_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out, array_rdata, wr_data;
    logic [AW-1:0] array_addr, wr_addr;
    logic [2:0] bus_op;
    logic dq_oe, standby, idle_standby, write_valid;

    int compared = 0, mismatched = 0, wr_count = 0;

    always #5 clk = ~clk;

    // Array model: each word is a fixed function of its address.
    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction
    assign array_rdata = word_of(array_addr);

    flash_bus_frontend i_flash_bus_frontend (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .array_addr(array_addr), .array_rdata(array_rdata), .bus_op(bus_op),
        .standby(standby), .idle_standby(idle_standby), .write_valid(write_valid),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Counts cycles in which write_valid is high, sampled between edges.
    always @(negedge clk) if (rst_n && write_valid) wr_count++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int base;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "dq_oe in reset", dq_oe, 0);
        chk("R1", "bus_op in reset", bus_op, 0);
        chk("R1", "standby in reset", standby, 1);
        chk("R1", "idle in reset", idle_standby, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "write_valid after reset", write_valid, 0);
        chk("R1", "dq_oe after reset", dq_oe, 0);

        // Table walk over all strobe combinations (R2, R3, R4, R7)
        addr = 19'h1_2345;
        for (int i = 0; i < 8; i++) begin
            {ce_n, we_n, oe_n} = VEC[i][7:5];
            settle(SETTLE);
            chk("R2_R3_R4_R7", "table bus_op", bus_op, VEC[i][4:2]);
            chk("R2_R3_R4_R7", "table dq_oe", dq_oe, VEC[i][1]);
            chk("R4", "table standby", standby, VEC[i][0]);
            if (VEC[i][1]) chk("R2", "table read data", dq_out, word_of(addr));
        end

        // R2: read follows the address
        ce_n = 0; we_n = 1; oe_n = 0; addr = 19'h0_0F0F;
        settle(SETTLE);
        chk("R2", "read data", dq_out, word_of(19'h0_0F0F));
        ce_n = 1; oe_n = 1; settle(SETTLE);

        // R5 R6: write ended and framed by the write strobe
        base = wr_count;
        ce_n = 0; addr = 19'h0_0AAA; dq_in = 16'h1111; settle(SETTLE);
        we_n = 0; settle(SETTLE);
        chk("R3", "bus_op during write", bus_op, 3);
        addr = 19'h7_7777; dq_in = 16'hBEEF; settle(SETTLE);
        we_n = 1; settle(SETTLE);
        dq_in = 16'h2222; settle(SETTLE);
        ce_n = 1; settle(SETTLE);
        chk("R6", "write-strobe write pulses", wr_count - base, 1);
        chk("R5", "address at later fall", wr_addr, 19'h0_0AAA);
        chk("R6", "data at first rise", wr_data, 16'hBEEF);

        // R5 R6: write ended and framed by chip select
        base = wr_count;
        we_n = 0; addr = 19'h5_0505; dq_in = 16'h3333; settle(SETTLE);
        ce_n = 0; settle(SETTLE);
        addr = 19'h6_6666; dq_in = 16'hCAFE; settle(SETTLE);
        ce_n = 1; settle(SETTLE);
        dq_in = 16'h4444; settle(SETTLE);
        we_n = 1; settle(SETTLE);
        chk("R6", "chip-select write pulses", wr_count - base, 1);
        chk("R5", "address at chip-select fall", wr_addr, 19'h5_0505);
        chk("R6", "data at chip-select rise", wr_data, 16'hCAFE);

        // R7: output strobe low during the overlap
        base = wr_count;
        we_n = 0; oe_n = 0; settle(SETTLE);
        ce_n = 0; settle(SETTLE);
        chk("R7", "contention bus_op", bus_op, 4);
        chk("R7", "contention dq_oe", dq_oe, 0);
        ce_n = 1; settle(SETTLE);
        oe_n = 1; ce_n = 0; settle(SETTLE);
        oe_n = 0; settle(SETTLE);
        oe_n = 1; settle(SETTLE);
        ce_n = 1; we_n = 1; settle(SETTLE);
        chk("R7", "no write with output strobe low", wr_count - base, 0);

        // R8: glitch filter on chip select and write strobe
        base = wr_count;
        we_n = 0; addr = 19'h0_1234; dq_in = 16'h5555; settle(SETTLE);
        ce_n = 0; settle(GLITCH_C - 1); ce_n = 1; settle(SETTLE);
        chk("R8", "short chip-select pulse", wr_count - base, 0);
        we_n = 1; ce_n = 0; settle(SETTLE);
        we_n = 0; settle(GLITCH_C - 1); we_n = 1; settle(SETTLE);
        chk("R8", "short write-strobe pulse", wr_count - base, 0);
        chk("R8", "bus_op after glitch", bus_op, 1);
        ce_n = 1; we_n = 0; settle(SETTLE);
        ce_n = 0; settle(GLITCH_C); ce_n = 1; settle(SETTLE);
        chk("R8", "minimum-length pulse accepted", wr_count - base, 1);
        chk("R8", "minimum-length pulse data", wr_data, 16'h5555);
        we_n = 1; settle(SETTLE);

        // R9 R10: idle boundary while a read is in progress
        ce_n = 0; oe_n = 0; addr = 19'h0_0100; settle(20);
        @(negedge clk) addr = 19'h0_0200;
        repeat (IDLE_C + 2) @(posedge clk);
        #1 chk("R9", "idle one edge early", idle_standby, 0);
        @(posedge clk);
        #1 chk("R9", "idle at limit", idle_standby, 1);
        chk("R10", "read drives while idle", dq_oe, 1);
        chk("R10", "read data while idle", dq_out, word_of(19'h0_0200));
        @(negedge clk) addr = 19'h0_0300;
        repeat (3) @(posedge clk);
        #1 chk("R10", "activity clears idle", idle_standby, 0);

        // R1: reset during a read
        @(negedge clk) rst_n = 0;
        @(negedge clk);
        chk("R1", "dq_oe after mid-read reset", dq_oe, 0);
        chk("R1", "bus_op after mid-read reset", bus_op, 0);

        summary();
    end
endmodule